// File: doc/BRIEF.md
# Clock Alive Monitor with Failover

This block judges whether an external oscillator clock is healthy by counting its rising edges inside a reference window. The window is timed by an independent, always-running backup clock. That backup clock is also the clock the whole block runs on. The raw oscillator is treated as data. It passes through a two-flop synchronizer, and each synchronized rising edge adds one to a counter. When the window closes, the edge total is compared with a programmable lower and upper limit. The window is then reported in one of four ways:
- good, when the total lies between the limits;
- dead, when no edge was seen;
- too slow, when the total is below the lower limit;
- too fast, when the total is above the upper limit.

Any failing window sets a sticky safety alarm. It also forces the registered clock-source select code to 00, which a separate clock multiplexer decodes as the backup clock. Software can only choose which source is selected; the backup clock itself has no enable or disable control. After a failover, a new source takes effect only when both of these have happened:
- software has written that source;
- the monitor has reported two consecutive good windows.

Configuration uses a small write port:

| Address | Meaning |
|---|---|
| 0 | Window length minus one, in backup-clock cycles |
| 1 | Lower edge limit |
| 2 | Upper edge limit |
| 3 | Source select request, bits 1:0 |
| 4 | Alarm clear: write bit 0 as 1 |

Top module: `clk_alive_mon`

## Requirements
- R1: Monitored-clock rising edges are taken through a two-flop synchronizer and counted over a window of (address 0 value + 1) backup-clock cycles. The reset window value is 31, which gives a 32-cycle window.
- R2: A window with zero edges raises `stat_dead` and clears the other two status flags.
- R3: A window whose edge total is nonzero but below the lower limit (address 1) raises `stat_slow`. A total equal to the lower limit counts as good.
- R4: A window whose edge total is above the upper limit (address 2) raises `stat_fast`. A total equal to the upper limit counts as good.
- R5: `win_end` pulses for one cycle each time a window closes, together with updated status flags. At most one status flag is high, and all three are low for a good window.
- R6: In the cycle where a failing window is reported, `alarm` is high and `clk_sel` is 00.
- R7: `alarm` is sticky. It clears only on a write to address 4 with bit 0 set; a write there with bit 0 clear has no effect.
- R8: `clk_sel` resets to 00, the backup clock. When no failover is in force, a write to address 3 loads bits 1:0 into `clk_sel` at that clock edge.
- R9: After a failover, `clk_sel` holds 00 until software has written a new select and two consecutive good windows have been reported, in either order. Release happens one cycle after both conditions are met, and any failing window restarts the good-window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backup clock; times the window and runs all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_clk | input | 1 | Raw monitored oscillator clock |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration address |
| wr_data | input | 16 | Configuration write data |
| clk_sel | output | 2 | Registered clock-source select; 00 is the backup clock |
| alarm | output | 1 | Sticky safety alarm |
| win_end | output | 1 | One-cycle pulse when a window result is posted |
| stat_dead | output | 1 | Last window saw no edges |
| stat_slow | output | 1 | Last window was below the lower limit |
| stat_fast | output | 1 | Last window was above the upper limit |

## Verification
A wrong edge count or a wrong window length shows up as a wrong status flag within two windows, for any steady monitored period that divides the window evenly. Stimuli are therefore placed exactly on the limits, and one step past each of them. A failover lock that is never cleared leaves `clk_sel` stuck at 00 one cycle after the second good window. A lock that is cleared too early makes the requested code appear before that point. A broken sticky alarm shows up as `alarm` dropping during good windows, or surviving a clear write.

// File: rtl/clk_alive_mon.sv
module clk_alive_mon #(
  parameter int WIN_W  = 12,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16,
  parameter int DEF_WIN = 31,
  parameter int DEF_LO  = 4,
  parameter int DEF_HI  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_clk,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        clk_sel,
  output logic              alarm,
  output logic              win_end,
  output logic              stat_dead,
  output logic              stat_slow,
  output logic              stat_fast
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       sync_q;
  logic [WIN_W-1:0] win_len, win_cnt;
  logic [CNT_W-1:0] lim_lo, lim_hi, edge_cnt;
  logic [1:0]       sel_req, good_run;
  logic             locked, pend;

  wire rise      = sync_q[1] & ~sync_q[2];
  wire win_close = (win_cnt >= win_len);
  wire [CNT_W-1:0] total = (edge_cnt == CNT_MAX) ? edge_cnt : edge_cnt + CNT_W'(rise);
  wire is_dead   = (total == '0);
  wire is_slow   = !is_dead && (total < lim_lo);
  wire is_fast   = (total > lim_hi);
  wire bad_now   = win_close && (is_dead || is_slow || is_fast);
  wire good_now  = win_close && !bad_now;
  wire sel_wr    = wr_en && (wr_addr == 3'd3);
  wire clr_wr    = wr_en && (wr_addr == 3'd4) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], mon_clk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_len <= WIN_W'(DEF_WIN);
      lim_lo  <= CNT_W'(DEF_LO);
      lim_hi  <= CNT_W'(DEF_HI);
    end else if (wr_en) begin
      case (wr_addr)
        3'd0:    win_len <= wr_data[WIN_W-1:0];
        3'd1:    lim_lo  <= wr_data[CNT_W-1:0];
        3'd2:    lim_hi  <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      edge_cnt  <= '0;
      win_end   <= 1'b0;
      stat_dead <= 1'b0;
      stat_slow <= 1'b0;
      stat_fast <= 1'b0;
    end else if (win_close) begin
      win_cnt   <= '0;
      edge_cnt  <= '0;
      win_end   <= 1'b1;
      stat_dead <= is_dead;
      stat_slow <= is_slow;
      stat_fast <= is_fast && !is_dead;
    end else begin
      win_cnt  <= win_cnt + 1'b1;
      edge_cnt <= total;
      win_end  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel  <= 2'b00;
      sel_req  <= 2'b00;
      pend     <= 1'b0;
      locked   <= 1'b0;
      good_run <= '0;
      alarm    <= 1'b0;
    end else begin
      if (clr_wr) alarm <= 1'b0;
      if (good_now && locked && good_run != 2'd2) good_run <= good_run + 1'b1;
      if (sel_wr) begin
        sel_req <= wr_data[1:0];
        if (locked || bad_now) pend <= 1'b1;
        else                   clk_sel <= wr_data[1:0];
      end
      if (locked && pend && good_run == 2'd2 && !bad_now) begin
        clk_sel <= sel_req;
        locked  <= 1'b0;
        pend    <= 1'b0;
      end
      if (bad_now) begin
        alarm    <= 1'b1;
        clk_sel  <= 2'b00;
        locked   <= 1'b1;
        good_run <= '0;
      end
    end
  end
endmodule

module clk_alive_mon_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic [1:0]  clk_sel,
  input logic        alarm,
  input logic        win_end,
  input logic        stat_dead,
  input logic        stat_slow,
  input logic        stat_fast
);
  // R5
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_dead, stat_slow, stat_fast}));

  // R6
  fail_forces_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && (stat_dead || stat_slow || stat_fast)) |-> (clk_sel == 2'b00 && alarm));

  // R7
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !(wr_en && wr_addr == 3'd4 && wr_data[0])) |=> alarm);

  // R6
  alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> (win_end && (stat_dead || stat_slow || stat_fast)));

  // R9
  sel_hold_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && (stat_dead || stat_slow || stat_fast)) |=> (clk_sel == 2'b00));
endmodule

bind clk_alive_mon clk_alive_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .clk_sel(clk_sel), .alarm(alarm), .win_end(win_end),
  .stat_dead(stat_dead), .stat_slow(stat_slow), .stat_fast(stat_fast)
);

// File: tb/tb_clk_alive_mon.sv
module tb_clk_alive_mon;
  logic clk = 1'b0, rst_n = 1'b0, mon_clk = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] clk_sel;
  logic alarm, win_end, stat_dead, stat_slow, stat_fast;
  int total = 0, bad = 0, cyc = 0, period = 4, pc = 0;

  clk_alive_mon dut (.*);

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (period == 0) mon_clk <= 1'b0;
    else begin
      pc = (pc + 1) % period;
      mon_clk <= (pc < period / 2);
    end
  end

  // fields: period[25:18] lo[17:10] hi[9:2] verdict[1:0] (0 good,1 dead,2 slow,3 fast)
  localparam logic [25:0] VEC [7] = '{
    {8'd4,  8'd4, 8'd8, 2'd0},   // R1 8 edges
    {8'd2,  8'd4, 8'd8, 2'd3},   // R4 16 edges
    {8'd8,  8'd4, 8'd8, 2'd0},   // R3 4 == lo
    {8'd8,  8'd5, 8'd8, 2'd2},   // R3 4 < lo
    {8'd4,  8'd4, 8'd7, 2'd3},   // R4 8 > hi
    {8'd0,  8'd4, 8'd8, 2'd1},   // R2 stopped
    {8'd16, 8'd4, 8'd8, 2'd2}    // R3 2 edges
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_win();
    int n = 0;
    @(negedge clk);
    while (!win_end && n < 2000) begin @(negedge clk); n++; end
  endtask

  function automatic int verdict();
    return stat_dead ? 1 : stat_slow ? 2 : stat_fast ? 3 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(clk_sel == 2'b00, "R8 reset sel", clk_sel, 0);
    check(alarm == 1'b0, "R7 reset alarm", alarm, 0);
    check(verdict() == 0 && !win_end, "R5 reset status", verdict(), 0);
    rst_n = 1'b1;

    wait_win(); wait_win();
    check(verdict() == 0, "R1 default window good", verdict(), 0);
    wr(3, 2);
    check(clk_sel == 2'd2, "R8 direct select", clk_sel, 2);

    foreach (VEC[i]) begin
      period = int'(VEC[i][25:18]);
      wr(1, int'(VEC[i][17:10]));
      wr(2, int'(VEC[i][9:2]));
      wait_win(); wait_win();
      check(verdict() == int'(VEC[i][1:0]), $sformatf("R2/R3/R4 row %0d", i),
            verdict(), int'(VEC[i][1:0]));
      if (VEC[i][1:0] != 2'd0)
        check(clk_sel == 2'b00 && alarm, "R6 failover", {alarm, clk_sel}, 4);
    end

    // R7 sticky and clear
    period = 4; wr(1, 4); wr(2, 8);
    wait_win(); wait_win();
    check(alarm == 1'b1, "R7 sticky through good", alarm, 1);
    wr(4, 0);
    check(alarm == 1'b1, "R7 bit0 clear ignored", alarm, 1);
    wr(4, 1);
    check(alarm == 1'b0, "R7 cleared", alarm, 0);

    // R9 write during failure, then two good windows
    period = 2; wait_win(); wait_win();
    check(stat_fast && clk_sel == 0, "R6 fast fail", clk_sel, 0);
    wr(3, 1);
    check(clk_sel == 2'b00, "R9 locked write held", clk_sel, 0);
    period = 4;
    wait_win();
    while (verdict() != 0) wait_win();
    check(clk_sel == 2'b00, "R9 after first good", clk_sel, 0);
    wait_win();
    check(clk_sel == 2'b00, "R9 at second good", clk_sel, 0);
    @(negedge clk);
    check(clk_sel == 2'd1, "R9 release", clk_sel, 1);

    // R9 good windows alone do not release
    period = 0; wait_win(); wait_win();
    check(stat_dead && clk_sel == 0, "R2 dead fail", clk_sel, 0);
    period = 4;
    repeat (4) wait_win();
    check(clk_sel == 2'b00, "R9 no write no release", clk_sel, 0);
    wr(3, 3);
    @(negedge clk);
    check(clk_sel == 2'd3, "R9 write after good windows", clk_sel, 3);

    // R1 shorter window: 16 cycles, period 4 -> 4 edges
    wr(0, 15); wr(1, 4); wr(2, 4);
    wait_win(); wait_win();
    check(verdict() == 0, "R1 window length 16", verdict(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule